// File: doc/BRIEF.md
# Bus Master Performance Counter Register

This block is a 32-bit read-only status word that measures bus-master activity. Its upper half counts the bus clock cycles spent waiting on read commands. A read wait runs from the cycle a read request starts up to the cycle that access completes. Its low byte counts the double words the bus master has moved. Both counts accumulate over any number of transactions and return to zero when software reads the register.

Four single-cycle strobes drive the block: request start, access complete, one double word transferred, and register read. The register value appears at the output at all times. A read strobe takes the value shown in that cycle and clears the counts behind it. Any event that arrives in the same cycle as a read is kept as the first count of the new interval, so no event is lost. Each count stops at its all-ones value and does not wrap.

Top module: `bm_perf_counter`

## Requirements
- R1: Bits 31:16 count one for each cycle from the request-start cycle up to, but not including, the cycle in which the access-complete pulse arrives.
- R2: The wait-cycle field adds up over several read requests that occur between two register reads.
- R3: Bits 7:0 count one for each cycle in which the double-word strobe is high, accumulated since the last register read.
- R4: Bits 15:8 always read as zero.
- R5: A read strobe returns the value shown in that cycle. Both fields then hold only the events of the read cycle itself.
- R6: After a synchronous active-high reset, the output is all zeros.
- R7: The wait-cycle field stops at 0xFFFF and stays there until a read.
- R8: The double-word field stops at 0xFF and stays there until a read.
- R9: A wait cycle or a double-word strobe that arrives in the read cycle becomes a count of 1 in the new interval.
- R10: A start pulse while a request is already open is ignored. A complete pulse with no open request is ignored. Start and complete in the same cycle with no open request count zero cycles. Complete and start together on an open request close it and open a new one, and that cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req_start_i | input | 1 | Pulse: a read request is asserted |
| rd_acc_done_i | input | 1 | Pulse: the pending read access has completed |
| dword_xfer_i | input | 1 | One double word transferred by the bus master this cycle |
| csr_rd_i | input | 1 | Register read strobe; clears both fields after this cycle |
| csr_val_o | output | 32 | Register value {wait cycles, 8'h00, double words} |

## Verification
A wrong open-request flag shows up at the next read as a wait count that is too large or too small. When that flag sticks high, the upper field keeps growing across reads that should return zero. A faulty clear or a dropped same-cycle event gives an error of one, visible at the read right after the event. The bench therefore reads back-to-back. A saturation fault only shows once a field passes its limit, so the bench drives one long request and a long run of double-word strobes past the all-ones values.

// File: rtl/bmpc_pkg.sv
package bmpc_pkg;

    // Field widths of the status word
    localparam int unsigned WAIT_W = 16;
    localparam int unsigned DW_W   = 8;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned RSV_W  = REG_W - WAIT_W - DW_W;

    // Input event bundle sampled each cycle
    typedef struct packed {
        logic start;
        logic done;
        logic dword;
        logic rd;
    } perf_evt_t;

    // Register layout
    typedef struct packed {
        logic [WAIT_W-1:0] wait_clks;
        logic [RSV_W-1:0]  rsv;
        logic [DW_W-1:0]   dwords;
    } perf_reg_t;

    // Next value of the open-request flag
    function automatic logic open_next(logic open_q, logic start, logic done);
        if (open_q) return done ? start : 1'b1;
        return start & ~done;
    endfunction

    // Whether this cycle counts as a wait cycle
    function automatic logic wait_count(logic open_q, logic start, logic done);
        return (open_q | start) & ~done;
    endfunction

endpackage

// File: rtl/bmpc_lat_track.sv
module bmpc_lat_track
    import bmpc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic done_i,
    output logic open_o,
    output logic wait_inc_o
);

    logic open_q;

    always_ff @(posedge clk) begin
        if (rst) open_q <= 1'b0;
        else     open_q <= open_next(open_q, start_i, done_i);
    end

    assign open_o     = open_q;
    assign wait_inc_o = wait_count(open_q, start_i, done_i);

    // R10: a completion closes the request unless a new start comes with it
    a_r10_done_closes: assert property (@(posedge clk) disable iff (rst)
        (done_i && !start_i) |=> !open_q);

    // R1: a start with no completion leaves a request open
    a_r1_start_opens: assert property (@(posedge clk) disable iff (rst)
        (start_i && !done_i) |=> open_q);

endmodule

// File: rtl/bmpc_sat_acc.sv
module bmpc_sat_acc #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    always_comb begin
        if (clr_i)
            cnt_d = inc_i ? ONE : '0;
        else if (inc_i && cnt_q != MAXV)
            cnt_d = cnt_q + ONE;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R7/R8: a full counter stays full until cleared
    a_r7_sat_hold: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == MAXV && !clr_i) |=> cnt_q == MAXV);

    // R5: after a clear only the read-cycle event can remain
    a_r5_clear_restart: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> cnt_q <= ONE);

    // R2: without a clear the count never goes down
    a_r2_monotone: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> cnt_q >= $past(cnt_q));

    // R9: an event in the read cycle is kept
    a_r9_keep_event: assert property (@(posedge clk) disable iff (rst)
        (clr_i && inc_i) |=> cnt_q == ONE);

endmodule

// File: rtl/bm_perf_counter.sv
module bm_perf_counter
    import bmpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req_start_i,
    input  logic              rd_acc_done_i,
    input  logic              dword_xfer_i,
    input  logic              csr_rd_i,
    output logic [REG_W-1:0]  csr_val_o
);

    perf_evt_t          evt;
    perf_reg_t          val;
    logic               req_open;
    logic               wait_inc;
    logic [WAIT_W-1:0]  wait_cnt;
    logic [DW_W-1:0]    dw_cnt;

    assign evt = '{start: rd_req_start_i, done: rd_acc_done_i,
                   dword: dword_xfer_i,   rd:   csr_rd_i};

    bmpc_lat_track u_track (
        .clk        (clk),
        .rst        (rst),
        .start_i    (evt.start),
        .done_i     (evt.done),
        .open_o     (req_open),
        .wait_inc_o (wait_inc)
    );

    bmpc_sat_acc #(.W(WAIT_W)) u_wait_acc (
        .clk   (clk),
        .rst   (rst),
        .inc_i (wait_inc),
        .clr_i (evt.rd),
        .cnt_o (wait_cnt)
    );

    bmpc_sat_acc #(.W(DW_W)) u_dw_acc (
        .clk   (clk),
        .rst   (rst),
        .inc_i (evt.dword),
        .clr_i (evt.rd),
        .cnt_o (dw_cnt)
    );

    always_comb begin
        val.wait_clks = wait_cnt;
        val.rsv       = '0;
        val.dwords    = dw_cnt;
    end

    assign csr_val_o = val;

    // R4: reserved byte reads zero
    a_r4_rsv_zero: assert property (@(posedge clk) disable iff (rst)
        csr_val_o[15:8] == '0);

    // R6: reset leaves the word cleared
    a_r6_reset_zero: assert property (@(posedge clk)
        rst |=> csr_val_o == '0);

    // R1: no open request and no start leaves the wait field unchanged
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!req_open && !rd_req_start_i && !csr_rd_i) |=> $stable(csr_val_o[31:16]));

    // R3: no strobe and no read leaves the double-word field unchanged
    a_r3_dw_hold: assert property (@(posedge clk) disable iff (rst)
        (!dword_xfer_i && !csr_rd_i) |=> $stable(csr_val_o[7:0]));

endmodule

// File: tb/bm_perf_counter_tb_top.sv
module bm_perf_counter_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        st, dn, dw, rd;
    logic [31:0] val;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    int          total = 0;
    int          bad   = 0;
    bit          ended = 0;

    // reference model state
    bit          m_open = 0;
    int unsigned m_wait = 0;
    int unsigned m_dw   = 0;

    always #5 clk = ~clk;

    bm_perf_counter dut_i (
        .clk            (clk),
        .rst            (rst),
        .rd_req_start_i (st),
        .rd_acc_done_i  (dn),
        .dword_xfer_i   (dw),
        .csr_rd_i       (rd),
        .csr_val_o      (val)
    );

    // one cycle of stimulus, model updated from the requirements
    task automatic cyc(input bit s, input bit d, input bit x, input bit r, input string tag);
        bit winc;
        @(negedge clk);
        st = s; dn = d; dw = x; rd = r;
        if (r) sb_q.push_back('{exp: {m_wait[15:0], 8'h00, m_dw[7:0]}, tag: tag});
        // R1/R10: count start cycle and open cycles, never the completion cycle
        winc = (m_open || s) && !d;
        if (m_open) m_open = d ? s : 1'b1;
        else        m_open = s && !d;
        if (r) begin
            m_wait = winc ? 1 : 0;   // R9
            m_dw   = x ? 1 : 0;
        end else begin
            if (winc && m_wait < 16'hFFFF) m_wait++;   // R7
            if (x && m_dw < 8'hFF) m_dw++;             // R8
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, "");
    endtask

    // monitor: check each read away from the clock edges
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (!rst && rd) begin
                item_t it;
                total++;
                if (sb_q.size() == 0) begin
                    bad++;
                    $display("FAIL unexpected read: actual=%h expected=none", val);
                end else begin
                    it = sb_q.pop_front();
                    if (val !== it.exp) begin
                        bad++;
                        $display("FAIL %s: actual=%h expected=%h", it.tag, val, it.exp);
                    end
                end
                total++;
                if (val[15:8] !== 8'h00) begin
                    bad++;
                    $display("FAIL R4 reserved: actual=%h expected=00", val[15:8]);
                end
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        rst = 1; st = 0; dn = 0; dw = 0; rd = 0;
        repeat (3) @(negedge clk);
        // R6: reset value, checked right after reset goes low
        @(negedge clk); rst = 0;
        #3;
        total++;
        if (val !== 32'h0) begin
            bad++;
            $display("FAIL R6 reset: actual=%h expected=00000000", val);
        end
        cyc(0, 0, 0, 1, "R6 reset read");

        // R1: one request, start plus four waiting cycles
        cyc(1, 0, 0, 0, "");
        idle(4);
        cyc(0, 1, 0, 0, "");
        idle(2);
        cyc(0, 0, 0, 1, "R1 single request");

        // R2/R3: two requests with double words interleaved
        cyc(1, 0, 1, 0, "");
        cyc(0, 0, 1, 0, "");
        cyc(0, 0, 0, 0, "");
        cyc(0, 1, 1, 0, "");
        cyc(0, 0, 1, 0, "");
        cyc(1, 0, 0, 0, "");
        cyc(0, 1, 1, 0, "");
        cyc(0, 0, 0, 1, "R2 R3 accumulate");

        // R5/R9: events in read cycles, back-to-back reads
        cyc(0, 0, 1, 0, "");
        cyc(0, 0, 1, 1, "R5 read returns old");
        cyc(1, 0, 0, 1, "R9 dword kept");
        cyc(0, 0, 1, 1, "R9 wait kept");
        cyc(0, 1, 0, 1, "R9 both kept");
        cyc(0, 0, 0, 1, "R5 cleared");

        // R10: ignored and zero-length cases
        cyc(1, 1, 0, 0, "");
        cyc(0, 1, 0, 0, "");
        idle(2);
        cyc(0, 0, 0, 1, "R10 zero length");
        cyc(1, 0, 0, 0, "");
        cyc(1, 0, 0, 0, "");
        cyc(0, 0, 0, 0, "");
        cyc(1, 1, 0, 0, "");
        cyc(0, 0, 0, 0, "");
        cyc(0, 1, 0, 0, "");
        cyc(0, 0, 0, 1, "R10 restart and ignore");

        // R8: double-word saturation
        for (int i = 0; i < 300; i++) cyc(0, 0, 1, 0, "");
        cyc(0, 0, 0, 1, "R8 dword saturate");
        cyc(0, 0, 0, 1, "R8 cleared after saturate");

        // R7: wait-field saturation
        cyc(1, 0, 0, 0, "");
        idle(70000);
        cyc(0, 1, 0, 0, "");
        cyc(0, 0, 0, 1, "R7 wait saturate");
        cyc(0, 0, 0, 1, "R7 cleared after saturate");

        cyc(0, 0, 0, 0, "");
        idle(2);
        if (sb_q.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", sb_q.size());
        end
        finish_run();
    end

endmodule